// File: doc/BRIEF.md
# Integer Shift Datapath with Carry

This block is the combinational core of a scalar integer shift unit. It takes a 64-bit source operand and a 64-bit amount register and produces a shifted 64-bit result plus a two-bit carry field. Three operations are supported: shift left, shift right (logical or arithmetic), and a combined operation that sign-extends the lower word and then shifts left. A flag selects between 32-bit and 64-bit behaviour, and another flag selects arithmetic right shift.

The amount is read from a different number of low bits depending on the mode. As a result, amounts at or past the operand width flush the result instead of wrapping around. An arithmetic right shift of a negative value reports a carry whenever one bits fall off the low end. An opaque operation-context word and a routing tag travel through unchanged, so the surrounding pipeline stage can register them together with the result.

Top module: `sft_unit`

## Requirements
- R1: Left shift (`op_i`=0) with `is32_i`=1 shifts by `amt_i[5:0]` and returns bits 31..0 of the shifted value, with bits 63..32 of the result zero. Bits of `amt_i` above bit 5 have no effect, and amounts 32..63 give zero.
- R2: Left shift with `is32_i`=0 shifts by `amt_i[6:0]`. Amounts 64..127 give an all-zero result, and bits of `amt_i` above bit 6 have no effect.
- R3: Right shift (`op_i`=1) with `signed_i`=0 is logical. With `is32_i`=1 it shifts the zero-extended low word by `amt_i[5:0]`. With `is32_i`=0 it shifts the full source by `amt_i[6:0]`. In both cases, amounts at or beyond the operand width give zero.
- R4: Right shift with `signed_i`=1 is arithmetic. In 32-bit mode bit 31 is copied into bits 63..32 before the shift, and the result is returned sign-extended to 64 bits. In 64-bit mode bit 63 is the sign.
- R5: An arithmetic right shift by an amount at or beyond the operand width returns 64 copies of the operand's sign bit.
- R6: For an arithmetic right shift, carry is 1 exactly when the operand is negative and at least one 1 bit is shifted out. A shift by zero never sets carry. The carry value appears on both bits of `carry_o`.
- R7: Left shift, logical right shift and extend-then-shift always give `carry_o`=0, even for negative sources.
- R8: Extend-then-shift (`op_i`=2) sign-extends `src_i[31:0]` to 64 bits and shifts left by `amt_i[5:0]`. `is32_i` and `signed_i` have no effect on it.
- R9: The reserved code `op_i`=3 gives a zero result and zero carry.
- R10: `ctx_o` and `tag_o` equal `ctx_i` and `tag_i` in the same cycle, whatever the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| amt_i | input | 64 | Shift amount register (only low bits used) |
| op_i | input | 2 | 0 left, 1 right, 2 extend-then-shift, 3 reserved |
| is32_i | input | 1 | 32-bit mode |
| signed_i | input | 1 | Arithmetic right shift |
| ctx_i | input | CTX_W (16) | Operation context in |
| tag_i | input | TAG_W (2) | Routing tag in |
| result_o | output | 64 | Shifted result |
| carry_o | output | 2 | Carry, both bits equal |
| ctx_o | output | CTX_W (16) | Operation context out |
| tag_o | output | TAG_W (2) | Routing tag out |

## Verification
The bench targets amounts that sit exactly on the width boundaries (31/32, 63/64, 127), where a design that masks the amount to the wrong width wraps around and returns a non-zero value. It sets the high bits of the amount register in places that a correct design ignores; reading those bits would flush the result. Negative operands with and without one bits below the shift point catch a carry that tests the wrong bits or forgets the sign, and positive operands that lose one bits catch a carry that ignores the sign. Sweeps of every amount for 32-bit left shifts and 64-bit arithmetic right shifts expose a barrel stage with a wrong span or the wrong fill bit.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = 2 * DATA_W;
    localparam int AMT_W  = $clog2(DATA_W) + 1;
    localparam int NAMT_W = $clog2(HALF_W) + 1;

    typedef enum logic [1:0] {
        SFT_OP_SHL  = 2'd0,
        SFT_OP_SHR  = 2'd1,
        SFT_OP_EXTS = 2'd2,
        SFT_OP_RSVD = 2'd3
    } sft_op_e;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic [AMT_W-1:0] amt;
    } sft_prep_t;

    function automatic logic [EXT_W-1:0] widen(input logic [DATA_W-1:0] v,
                                               input logic              fill);
        return {{(EXT_W-DATA_W){fill}}, v};
    endfunction

endpackage

// File: rtl/sft_operand_prep.sv
module sft_operand_prep
    import sft_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] amt_reg,
    input  sft_op_e           op,
    input  logic              is32,
    input  logic              sgn,
    output sft_prep_t         prep
);
    logic              narrow;
    logic              use_sign;
    logic [DATA_W-1:0] word;
    logic              fill;
    logic              unused_amt_hi;

    assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

    always_comb begin
        narrow   = is32 || (op == SFT_OP_EXTS);
        use_sign = (op == SFT_OP_EXTS) || ((op == SFT_OP_SHR) && sgn);
        if (narrow) begin
            fill = use_sign & src[HALF_W-1];
            word = {{HALF_W{fill}}, src[HALF_W-1:0]};
        end else begin
            fill = use_sign & src[DATA_W-1];
            word = src;
        end
        prep.ext = widen(word, fill);
        if (narrow)
            prep.amt = {{(AMT_W-NAMT_W){1'b0}}, amt_reg[NAMT_W-1:0]};
        else
            prep.amt = amt_reg[AMT_W-1:0];
    end

endmodule

// File: rtl/sft_barrel.sv
module sft_barrel #(
    parameter int W      = 128,
    parameter int AW     = 7,
    parameter bit GO_LEFT = 1'b1
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SPAN = 2 ** k;
        if (GO_LEFT) begin : g_left
            assign stg[k+1] = amt[k] ? (stg[k] << SPAN) : stg[k];
        end else begin : g_right
            assign stg[k+1] = amt[k] ? W'($signed(stg[k]) >>> SPAN) : stg[k];
        end
    end

    assign dout = stg[AW];

    always_comb begin
        AST_ZERO_AMT_IDENT: assert ((amt != '0) || (dout == din)) // R6
            else $error("barrel changed data for zero amount");
    end

endmodule

// File: rtl/sft_carry.sv
module sft_carry #(
    parameter int W  = 128,
    parameter int AW = 7
) (
    input  logic [W-1:0]  ext,
    input  logic [AW-1:0] amt,
    input  logic          enable,
    output logic          carry
);
    logic [W-1:0] lost;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign lost[i] = ext[i] & (AW'(i) < amt);
    end

    assign carry = enable & ext[W-1] & (|lost);

    always_comb begin
        AST_NO_CARRY_ZERO_AMT: assert ((amt != '0) || !carry) // R6
            else $error("carry on zero shift");
    end

endmodule

// File: rtl/sft_unit.sv
module sft_unit
    import sft_pkg::*;
#(
    parameter int CTX_W = 16,
    parameter int TAG_W = 2
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] amt_i,
    input  logic [1:0]        op_i,
    input  logic              is32_i,
    input  logic              signed_i,
    input  logic [CTX_W-1:0]  ctx_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [DATA_W-1:0] result_o,
    output logic [1:0]        carry_o,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [TAG_W-1:0]  tag_o
);
    sft_op_e          op;
    sft_prep_t        prep;
    logic [EXT_W-1:0] left_v;
    logic [EXT_W-1:0] right_v;
    logic             arith;
    logic             cy;
    logic             unused_hi;

    assign op    = sft_op_e'(op_i);
    assign arith = (op == SFT_OP_SHR) && signed_i;

    sft_operand_prep u_prep (
        .src     (src_i),
        .amt_reg (amt_i),
        .op      (op),
        .is32    (is32_i),
        .sgn     (signed_i),
        .prep    (prep)
    );

    sft_barrel #(.W(EXT_W), .AW(AMT_W), .GO_LEFT(1'b1)) u_left (
        .din  (prep.ext),
        .amt  (prep.amt),
        .dout (left_v)
    );

    sft_barrel #(.W(EXT_W), .AW(AMT_W), .GO_LEFT(1'b0)) u_right (
        .din  (prep.ext),
        .amt  (prep.amt),
        .dout (right_v)
    );

    sft_carry #(.W(EXT_W), .AW(AMT_W)) u_carry (
        .ext    (prep.ext),
        .amt    (prep.amt),
        .enable (arith),
        .carry  (cy)
    );

    assign unused_hi = ^{left_v[EXT_W-1:DATA_W], right_v[EXT_W-1:DATA_W]};

    always_comb begin
        unique case (op)
            SFT_OP_SHL:  result_o = is32_i ? {{HALF_W{1'b0}}, left_v[HALF_W-1:0]}
                                           : left_v[DATA_W-1:0];
            SFT_OP_SHR:  result_o = right_v[DATA_W-1:0];
            SFT_OP_EXTS: result_o = left_v[DATA_W-1:0];
            default:     result_o = '0;
        endcase
    end

    assign carry_o = {2{cy}};
    assign ctx_o   = ctx_i;
    assign tag_o   = tag_i;

    always_comb begin
        AST_SHL32_UPPER_ZERO: assert (!((op == SFT_OP_SHL) && is32_i) ||
                                      (result_o[DATA_W-1:HALF_W] == '0)) // R1
            else $error("32-bit left shift leaked upper bits");
        AST_SHL64_FLUSH: assert (!((op == SFT_OP_SHL) && !is32_i && amt_i[AMT_W-1]) ||
                                 (result_o == '0)) // R2
            else $error("64-bit left shift by >=64 not zero");
        AST_SHR_LOGIC_FLUSH: assert (!((op == SFT_OP_SHR) && !signed_i && !is32_i &&
                                       amt_i[AMT_W-1]) || (result_o == '0)) // R3
            else $error("logical right shift by >=64 not zero");
        AST_SHR_SATURATE: assert (!(arith && !is32_i && amt_i[AMT_W-1]) ||
                                  (result_o == {DATA_W{src_i[DATA_W-1]}})) // R5
            else $error("arithmetic shift did not saturate");
        AST_CARRY_SOURCE: assert ((carry_o == 2'b00) ||
                                  ((op == SFT_OP_SHR) && signed_i)) // R7
            else $error("carry from a non-arithmetic operation");
        AST_CARRY_NEEDS_NEG: assert ((carry_o == 2'b00) || result_o[DATA_W-1]) // R6
            else $error("carry with non-negative result");
    end

endmodule

// File: tb/sft_unit_tb.sv
module sft_unit_tb;

    localparam int CW = 16;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [63:0]   src, amt;
    logic [1:0]    op;
    logic          is32, sgn;
    logic [CW-1:0] ctx;
    logic [TW-1:0] tag;
    logic [63:0]   res;
    logic [1:0]    cy;
    logic [CW-1:0] ctx_q;
    logic [TW-1:0] tag_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sft_unit #(.CTX_W(CW), .TAG_W(TW)) u_dut (
        .src_i(src), .amt_i(amt), .op_i(op), .is32_i(is32), .signed_i(sgn),
        .ctx_i(ctx), .tag_i(tag),
        .result_o(res), .carry_o(cy), .ctx_o(ctx_q), .tag_o(tag_q)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        is32;
        logic        sgn;
        logic [63:0] src;
        logic [63:0] amt;
        logic [63:0] res;
        logic [1:0]  cy;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 64'h1,                  64'd4,    64'h10,                 2'b00, 8'd2}, // R2
        '{2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64,   64'h0,                  2'b00, 8'd2}, // R2
        '{2'd0, 1'b0, 1'b0, 64'h1,                  64'h83,   64'h8,                  2'b00, 8'd2}, // R2
        '{2'd0, 1'b1, 1'b0, 64'h0000_0000_8000_0001, 64'd1,    64'h2,                  2'b00, 8'd1}, // R1
        '{2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h44,   64'hFFFF_FFF0,          2'b00, 8'd1}, // R1
        '{2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF,          64'd32,   64'h0,                  2'b00, 8'd1}, // R1
        '{2'd1, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd63,   64'h1,                  2'b00, 8'd3}, // R3
        '{2'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd31,   64'h1,                  2'b00, 8'd3}, // R3
        '{2'd1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd100,  64'h0,                  2'b00, 8'd3}, // R3
        '{2'd1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 64'd4,    64'hFFFF_FFFF_FFFF_FFF0, 2'b00, 8'd4}, // R4
        '{2'd1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF01, 64'd4,    64'hFFFF_FFFF_FFFF_FFF0, 2'b11, 8'd6}, // R6
        '{2'd1, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd4,    64'hFFFF_FFFF_F800_0000, 2'b00, 8'd4}, // R4
        '{2'd1, 1'b1, 1'b1, 64'h0000_0000_8000_0001, 64'd1,    64'hFFFF_FFFF_C000_0000, 2'b11, 8'd6}, // R6
        '{2'd1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd64,   64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 8'd5}, // R5
        '{2'd1, 1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd127,  64'h0,                  2'b00, 8'd5}, // R5
        '{2'd1, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd40,   64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 8'd5}, // R5
        '{2'd1, 1'b0, 1'b1, 64'hF,                  64'd2,    64'h3,                  2'b00, 8'd6}, // R6
        '{2'd2, 1'b1, 1'b1, 64'h1234_5678_8000_0001, 64'd4,    64'hFFFF_FFF8_0000_0010, 2'b00, 8'd8}, // R8
        '{2'd2, 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h48,   64'h0000_007F_FFFF_FF00, 2'b00, 8'd8}, // R8
        '{2'd3, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,    64'h0,                  2'b00, 8'd9}, // R9
        '{2'd1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4,    64'h0FFF_FFFF_FFFF_FFFF, 2'b00, 8'd7}  // R7
    };

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic w32, input logic s,
                         input logic [63:0] a, input logic [63:0] b);
        @(posedge clk);
        #1;
        op = o; is32 = w32; sgn = s; src = a; amt = b;
        @(negedge clk);
    endtask

    // Bench model for 64-bit arithmetic right shift, one bit per step
    function automatic logic [65:0] model_sra64(input logic [63:0] a, input int n);
        logic [63:0] v = a;
        logic        lost = 1'b0;
        for (int s = 0; s < n; s++) begin
            lost = lost | v[0];
            v    = {v[63], v[63:1]};
        end
        return {{2{a[63] & lost}}, v};
    endfunction

    function automatic logic [63:0] model_shl32(input logic [63:0] a, input int n);
        logic [31:0] v = a[31:0];
        for (int s = 0; s < n; s++) v = {v[30:0], 1'b0};
        return {32'h0, v};
    endfunction

    initial begin
        op = 2'd0; is32 = 1'b0; sgn = 1'b0; src = '0; amt = '0; ctx = '0; tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state with idle inputs: R10 and R7
        check64("R10 reset ctx", 64'(ctx_q), 64'h0);
        check64("R7 reset carry", 64'(cy), 64'h0);
        check64("R2 reset result", res, 64'h0);
        @(posedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].is32, VEC[i].sgn, VEC[i].src, VEC[i].amt);
            check64($sformatf("R%0d vec %0d result", VEC[i].req, i), res, VEC[i].res);
            check64($sformatf("R%0d vec %0d carry", VEC[i].req, i), 64'(cy), 64'(VEC[i].cy));
        end

        // R8: mode and signed flags do not matter for extend-then-shift
        for (int f = 0; f < 4; f++) begin
            drive(2'd2, f[0], f[1], 64'hAAAA_AAAA_8000_0003, 64'hFFFF_FFFF_FFFF_FFC1);
            check64("R8 flags ignored", res, 64'hFFFF_FFFF_0000_0006);
            check64("R7 extend carry", 64'(cy), 64'h0);
        end

        // R4 R5 R6: every 7-bit amount, negative operand with mixed low bits
        for (int n = 0; n < 128; n++) begin
            logic [65:0] e;
            e = model_sra64(64'h9000_0000_0000_0A05, n);
            drive(2'd1, 1'b0, 1'b1, 64'h9000_0000_0000_0A05, 64'(n));
            check64($sformatf("R4 sweep %0d result", n), res, e[63:0]);
            check64($sformatf("R6 sweep %0d carry", n), 64'(cy), 64'(e[65:64]));
        end

        // R1: every 6-bit amount, with upper amount bits set
        for (int n = 0; n < 64; n++) begin
            drive(2'd0, 1'b1, 1'b0, 64'hDEAD_BEEF_C0DE_1234, {58'h3FF_FFFF_FFFF_FFFF, 6'(n)});
            check64($sformatf("R1 sweep %0d", n), res, model_shl32(64'hDEAD_BEEF_C0DE_1234, n));
        end

        // R10: context and tag pass through on several operations
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            ctx = 16'hA5C3 ^ 16'(k * 16'h1111);
            tag = 2'(k);
            drive(2'(k), k[0], 1'b1, 64'hFFFF_0000_FFFF_0000, 64'd8);
            check64("R10 ctx", 64'(ctx_q), 64'(16'hA5C3 ^ 16'(k * 16'h1111)));
            check64("R10 tag", 64'(tag_q), 64'(k));
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule